// File: doc/BRIEF.md
# Memory-Mapped Pin Controller with Edge and Level Interrupts

This block gives software control over a bank of general-purpose pins through a small 32-bit register bus. Each pin has a 2-bit drive style. The style can be input only, push-pull, or one of two open-drain flavours. The block drives an output value and an output enable toward each pad and takes back a raw pad level. Software can change the output word in three ways: it can write it whole, or it can use three write-one ports that set, clear or invert selected bits without a read-modify-write.

Incoming pad levels pass through a two-stage synchronizer. They become visible in the input register only for pins whose sampling gate is open. Any pin can report four kinds of event: a rising edge, a falling edge, a high level and a low level. Each kind has its own enable word and its own pending word, and a combined word marks a pin pending when any of its kinds is pending. A single interrupt line leaves the block. A configuration bit chooses whether that line is a level (the OR of everything pending) or a one-cycle pulse each time something new becomes pending.

The bus uses byte addresses. Bits [1:0] must be zero; a misaligned access counts as unmapped. A read returns data in the same cycle as the request.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every writable register is zero, every pad output enable is low and the interrupt line is low. The read-only identity word at 0x000 returns the pin count in bits [9:0] and the parameter VERSION (default 3) in bits [19:10].
- R2: The drive-style words start at 0x008, with 16 pins per word. Pin n uses bits [2(n mod 16)+1 : 2(n mod 16)] of the word at 0x008 + 4·(n/16), and the words read back as written. Style 0 (input only) holds the pad's output enable low and its output low.
- R3: Style 1 drives the output bit with the enable high. Style 2 always drives low and enables only while the output bit is 0. Style 3 always drives high and enables only while the output bit is 1.
- R4: A write to 0x180 loads the output word, and a read of 0x180 returns it.
- R5: At 0x200 each 1 bit sets the matching output bit, at 0x280 each 1 bit clears it, and at 0x300 each 1 bit inverts it. Bits written as 0 leave the output unchanged, and all three ports read as zero.
- R6: The word at 0x100 returns the synchronized pad level ANDed with the sampling-gate word at 0x080. A pad change becomes visible after the second rising clock edge.
- R7: Rise pending (0x600) and fall pending (0x680) are sticky. A bit is set only for a pin whose sampling gate is open and whose rise enable (0x380) or fall enable (0x400) is set. Writing 1 to a pending bit clears it.
- R8: High pending (0x700) equals high-enable (0x480) AND gate AND synchronized level. Low pending (0x780) equals low-enable (0x500) AND gate AND the inverted synchronized level. Writes to both are ignored.
- R9: The combined pending word at 0x580 is the bitwise OR of the four pending words.
- R10: With bit 0 of the configuration word at 0x004 clear, the interrupt line equals the OR of all pending bits.
- R11: With that bit set, the line is high for exactly one cycle after any pending bit goes from 0 to 1, and low otherwise.
- R12: Reads of unmapped or misaligned addresses return zero. Writes to them, to the identity word or to the input word change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| pad_in_i | input | NPINS | Raw pad levels |
| pad_out_o | output | NPINS | Value driven toward each pad |
| pad_oe_o | output | NPINS | Output enable toward each pad |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The assertions assume that the reset is released away from a clock edge. They also assume that only bus writes to the rise-pending address remove rise bits, so the sticky check is relaxed only in cycles with such a write. The drive-style checks assume nothing about the pads. The bench meets these assumptions: it changes the reset, the bus signals and the pad inputs only on falling edges, and it keeps every pad input stable for at least three cycles before it reads any state that depends on that input. This lets the synchronizer settle and the edge detector fire exactly once.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  typedef enum logic [1:0] {
    PM_INPUT    = 2'd0,
    PM_PUSHPULL = 2'd1,
    PM_OD_LOW   = 2'd2,
    PM_OD_HIGH  = 2'd3
  } pin_mode_e;

  // word indices (byte address >> 2)
  localparam logic [WIDX_W-1:0] W_INFO    = 10'h000;
  localparam logic [WIDX_W-1:0] W_CFG     = 10'h001;
  localparam logic [WIDX_W-1:0] W_MODE    = 10'h002;
  localparam logic [WIDX_W-1:0] W_SAMPLE  = 10'h020;
  localparam logic [WIDX_W-1:0] W_INPUT   = 10'h040;
  localparam logic [WIDX_W-1:0] W_OUT     = 10'h060;
  localparam logic [WIDX_W-1:0] W_SET     = 10'h080;
  localparam logic [WIDX_W-1:0] W_CLR     = 10'h0A0;
  localparam logic [WIDX_W-1:0] W_TGL     = 10'h0C0;
  localparam logic [WIDX_W-1:0] W_RISE_EN = 10'h0E0;
  localparam logic [WIDX_W-1:0] W_FALL_EN = 10'h100;
  localparam logic [WIDX_W-1:0] W_HIGH_EN = 10'h120;
  localparam logic [WIDX_W-1:0] W_LOW_EN  = 10'h140;
  localparam logic [WIDX_W-1:0] W_ANY_ST  = 10'h160;
  localparam logic [WIDX_W-1:0] W_RISE_ST = 10'h180;
  localparam logic [WIDX_W-1:0] W_FALL_ST = 10'h1A0;
  localparam logic [WIDX_W-1:0] W_HIGH_ST = 10'h1C0;
  localparam logic [WIDX_W-1:0] W_LOW_ST  = 10'h1E0;

endpackage

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic [2*NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]   out_i,
  output logic [NPINS-1:0]   pad_out_o,
  output logic [NPINS-1:0]   pad_oe_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_e style;
    assign style = pin_mode_e'(mode_i[2*p +: 2]);

    always_comb begin
      unique case (style)
        PM_PUSHPULL: begin pad_oe_o[p] = 1'b1;      pad_out_o[p] = out_i[p]; end
        PM_OD_LOW:   begin pad_oe_o[p] = ~out_i[p]; pad_out_o[p] = 1'b0;     end
        PM_OD_HIGH:  begin pad_oe_o[p] = out_i[p];  pad_out_o[p] = 1'b1;     end
        default:     begin pad_oe_o[p] = 1'b0;      pad_out_o[p] = 1'b0;     end
      endcase
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pad_i,
  input  logic [NPINS-1:0] sample_en_i,
  output logic [NPINS-1:0] sync_o,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);

  logic [NPINS-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sample_en_i &  sync_q & ~prev_q;
  assign fall_o = sample_en_i & ~sync_q &  prev_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] sync_i,
  input  logic [NPINS-1:0] sample_en_i,
  input  logic [NPINS-1:0] rise_evt_i,
  input  logic [NPINS-1:0] fall_evt_i,
  input  logic [NPINS-1:0] rise_en_i,
  input  logic [NPINS-1:0] fall_en_i,
  input  logic [NPINS-1:0] high_en_i,
  input  logic [NPINS-1:0] low_en_i,
  input  logic [NPINS-1:0] rise_clr_i,
  input  logic [NPINS-1:0] fall_clr_i,
  input  logic             pulse_mode_i,
  output logic [NPINS-1:0] rise_st_o,
  output logic [NPINS-1:0] fall_st_o,
  output logic [NPINS-1:0] high_st_o,
  output logic [NPINS-1:0] low_st_o,
  output logic [NPINS-1:0] any_st_o,
  output logic             irq_o
);

  localparam int unsigned PEND_W = 4 * NPINS;

  logic [NPINS-1:0]  rise_q, rise_d, fall_q, fall_d;
  logic [PEND_W-1:0] pend_all, pend_prev_q;

  // a new event wins over a clear in the same cycle
  always_comb begin
    rise_d = (rise_q & ~rise_clr_i) | (rise_evt_i & rise_en_i);
    fall_d = (fall_q & ~fall_clr_i) | (fall_evt_i & fall_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q      <= '0;
      fall_q      <= '0;
      pend_prev_q <= '0;
    end else begin
      rise_q      <= rise_d;
      fall_q      <= fall_d;
      pend_prev_q <= pend_all;
    end
  end

  assign high_st_o = high_en_i & sample_en_i &  sync_i;
  assign low_st_o  = low_en_i  & sample_en_i & ~sync_i;
  assign rise_st_o = rise_q;
  assign fall_st_o = fall_q;
  assign any_st_o  = rise_q | fall_q | high_st_o | low_st_o;
  assign pend_all  = {rise_q, fall_q, high_st_o, low_st_o};

  assign irq_o = pulse_mode_i ? |(pend_all & ~pend_prev_q) : |any_st_o;

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS   = 32,
  parameter logic [9:0]  VERSION = 10'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [11:0]       bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic              irq_o
);

  localparam int unsigned MODE_WORDS = (NPINS + 15) / 16;
  localparam int unsigned MODE_BITS  = 32 * MODE_WORDS;
  localparam logic [MODE_BITS-1:0] MODE_MASK =
    MODE_BITS'((128'(1) << (2 * NPINS)) - 128'(1));
  localparam logic [31:0] INFO_WORD = {12'd0, VERSION, 10'(NPINS)};

  // register state
  logic [MODE_BITS-1:0] mode_q, mode_d;
  logic                 cfg_q, cfg_d;
  logic [NPINS-1:0]     sample_en_q, sample_en_d;
  logic [NPINS-1:0]     out_q, out_d;
  logic [NPINS-1:0]     rise_en_q, rise_en_d, fall_en_q, fall_en_d;
  logic [NPINS-1:0]     high_en_q, high_en_d, low_en_q, low_en_d;

  // bus decode
  logic [WIDX_W-1:0] widx;
  logic              aligned, wr;
  logic [NPINS-1:0]  wpins;
  logic [NPINS-1:0]  set_v, clr_v, tgl_v, rise_clr, fall_clr;

  assign widx    = bus_addr_i[11:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign wr      = bus_req_i & bus_we_i & aligned;
  assign wpins   = bus_wdata_i[NPINS-1:0];

  // submodule results
  logic [NPINS-1:0] sync_lvl, rise_evt, fall_evt;
  logic [NPINS-1:0] rise_st, fall_st, high_st, low_st, any_st;

  gpio_pad_drive #(.NPINS(NPINS)) i_drive (
    .mode_i    (mode_q[2*NPINS-1:0]),
    .out_i     (out_q),
    .pad_out_o (pad_out_o),
    .pad_oe_o  (pad_oe_o)
  );

  gpio_in_sync #(.NPINS(NPINS)) i_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pad_i       (pad_in_i),
    .sample_en_i (sample_en_q),
    .sync_o      (sync_lvl),
    .rise_o      (rise_evt),
    .fall_o      (fall_evt)
  );

  gpio_irq_unit #(.NPINS(NPINS)) i_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sync_i       (sync_lvl),
    .sample_en_i  (sample_en_q),
    .rise_evt_i   (rise_evt),
    .fall_evt_i   (fall_evt),
    .rise_en_i    (rise_en_q),
    .fall_en_i    (fall_en_q),
    .high_en_i    (high_en_q),
    .low_en_i     (low_en_q),
    .rise_clr_i   (rise_clr),
    .fall_clr_i   (fall_clr),
    .pulse_mode_i (cfg_q),
    .rise_st_o    (rise_st),
    .fall_st_o    (fall_st),
    .high_st_o    (high_st),
    .low_st_o     (low_st),
    .any_st_o     (any_st),
    .irq_o        (irq_o)
  );

  // next-state
  always_comb begin
    mode_d      = mode_q;
    cfg_d       = cfg_q;
    sample_en_d = sample_en_q;
    out_d       = out_q;
    rise_en_d   = rise_en_q;
    fall_en_d   = fall_en_q;
    high_en_d   = high_en_q;
    low_en_d    = low_en_q;

    for (int k = 0; k < MODE_WORDS; k++) begin
      if (wr && widx == (W_MODE + WIDX_W'(k))) mode_d[32*k +: 32] = bus_wdata_i;
    end
    mode_d = mode_d & MODE_MASK;

    if (wr && widx == W_CFG)     cfg_d       = bus_wdata_i[0];
    if (wr && widx == W_SAMPLE)  sample_en_d = wpins;
    if (wr && widx == W_OUT)     out_d       = wpins;
    if (wr && widx == W_RISE_EN) rise_en_d   = wpins;
    if (wr && widx == W_FALL_EN) fall_en_d   = wpins;
    if (wr && widx == W_HIGH_EN) high_en_d   = wpins;
    if (wr && widx == W_LOW_EN)  low_en_d    = wpins;

    set_v = (wr && widx == W_SET) ? wpins : '0;
    clr_v = (wr && widx == W_CLR) ? wpins : '0;
    tgl_v = (wr && widx == W_TGL) ? wpins : '0;
    // set and clear first, toggle last
    out_d = ((out_d | set_v) & ~clr_v) ^ tgl_v;

    rise_clr = (wr && widx == W_RISE_ST) ? wpins : '0;
    fall_clr = (wr && widx == W_FALL_ST) ? wpins : '0;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= '0;
      cfg_q       <= 1'b0;
      sample_en_q <= '0;
      out_q       <= '0;
      rise_en_q   <= '0;
      fall_en_q   <= '0;
      high_en_q   <= '0;
      low_en_q    <= '0;
    end else begin
      mode_q      <= mode_d;
      cfg_q       <= cfg_d;
      sample_en_q <= sample_en_d;
      out_q       <= out_d;
      rise_en_q   <= rise_en_d;
      fall_en_q   <= fall_en_d;
      high_en_q   <= high_en_d;
      low_en_q    <= low_en_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata_o = '0;
    if (bus_req_i && aligned) begin
      unique case (widx)
        W_INFO:    bus_rdata_o = INFO_WORD;
        W_CFG:     bus_rdata_o = {31'd0, cfg_q};
        W_SAMPLE:  bus_rdata_o = 32'(sample_en_q);
        W_INPUT:   bus_rdata_o = 32'(sync_lvl & sample_en_q);
        W_OUT:     bus_rdata_o = 32'(out_q);
        W_RISE_EN: bus_rdata_o = 32'(rise_en_q);
        W_FALL_EN: bus_rdata_o = 32'(fall_en_q);
        W_HIGH_EN: bus_rdata_o = 32'(high_en_q);
        W_LOW_EN:  bus_rdata_o = 32'(low_en_q);
        W_ANY_ST:  bus_rdata_o = 32'(any_st);
        W_RISE_ST: bus_rdata_o = 32'(rise_st);
        W_FALL_ST: bus_rdata_o = 32'(fall_st);
        W_HIGH_ST: bus_rdata_o = 32'(high_st);
        W_LOW_ST:  bus_rdata_o = 32'(low_st);
        default:   bus_rdata_o = '0;
      endcase
      for (int k = 0; k < MODE_WORDS; k++) begin
        if (widx == (W_MODE + WIDX_W'(k))) bus_rdata_o = mode_q[32*k +: 32];
      end
    end
  end

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NPINS     = 32,
  parameter int unsigned MODE_BITS = 64
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_req_i,
  input logic                 bus_we_i,
  input logic [11:0]          bus_addr_i,
  input logic [MODE_BITS-1:0] mode_q,
  input logic                 cfg_q,
  input logic [NPINS-1:0]     sample_en_q,
  input logic [NPINS-1:0]     rise_st,
  input logic [NPINS-1:0]     any_st,
  input logic [NPINS-1:0]     pad_oe_o,
  input logic [NPINS-1:0]     pad_out_o,
  input logic                 irq_o
);

  logic [NPINS-1:0] is_input, is_od_low, is_od_high;
  logic             rise_clr_access;

  always_comb begin
    for (int p = 0; p < NPINS; p++) begin
      is_input[p]   = (mode_q[2*p +: 2] == 2'd0);
      is_od_low[p]  = (mode_q[2*p +: 2] == 2'd2);
      is_od_high[p] = (mode_q[2*p +: 2] == 2'd3);
    end
  end

  assign rise_clr_access = bus_req_i && bus_we_i &&
                           bus_addr_i == {W_RISE_ST, 2'b00};

  assert_input_released_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & is_input) == '0);

  assert_od_low_never_drives_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_out_o & is_od_low) == '0);

  assert_od_high_never_drives_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~pad_out_o & is_od_high) == '0);

  assert_rise_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_clr_access |=> (($past(rise_st) & ~rise_st) == '0));

  assert_rise_needs_sampling_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((rise_st & ~$past(rise_st) & ~$past(sample_en_q)) == '0));

  assert_level_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q |-> (irq_o == (|any_st)));

endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS), .MODE_BITS(MODE_BITS)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .mode_q      (mode_q),
  .cfg_q       (cfg_q),
  .sample_en_q (sample_en_q),
  .rise_st     (rise_st),
  .any_st      (any_st),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .irq_o       (irq_o)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;

  localparam int unsigned NPINS = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, we;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [31:0] pad_in, pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctrl #(.NPINS(NPINS), .VERSION(10'd3)) i_gpio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic void drive_ref(input logic [1:0] m, input logic [31:0] o, input int p,
                                    inout logic [31:0] oe, inout logic [31:0] po);
    case (m)
      2'd1:    begin oe[p] = 1'b1;  po[p] = o[p]; end
      2'd2:    begin oe[p] = ~o[p]; po[p] = 1'b0; end
      2'd3:    begin oe[p] = o[p];  po[p] = 1'b1; end
      default: begin oe[p] = 1'b0;  po[p] = 1'b0; end
    endcase
  endfunction

  // drive-style sweep: one uniform style or a mixed word
  task automatic mode_case(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] o);
    logic [31:0] eoe, eout;
    logic [63:0] modes;
    eoe = '0; eout = '0;
    modes = {w1, w0};
    wr(12'h008, w0);
    wr(12'h00C, w1);
    wr(12'h180, o);
    for (int p = 0; p < NPINS; p++) drive_ref(modes[2*p +: 2], o, p, eoe, eout);
    #1;
    chk("R2/R3 pad_oe", pad_oe, eoe);
    chk("R2/R3 pad_out", pad_out, eout);
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] model, d, en, pat;
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0; pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk("R1 pad_oe after reset", pad_oe, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);
    rd_chk("R1 out after reset", 12'h180, 32'h0);
    rd_chk("R1 mode after reset", 12'h008, 32'h0);
    rd_chk("R1 identity word", 12'h000, 32'd32 | (32'd3 << 10));

    // R2/R3 drive styles
    for (int m = 0; m < 4; m++) begin
      mode_case({16{2'(m)}}, {16{2'(m)}}, 32'hA5C3_0F96);
      mode_case({16{2'(m)}}, {16{2'(m)}}, 32'h5A3C_F069);
    end
    mode_case(32'hE4E4_E4E4, 32'h1B1B_1B1B, 32'hFF00_F0CC);
    rd_chk("R2 mode word 0 readback", 12'h008, 32'hE4E4_E4E4);
    rd_chk("R2 mode word 1 readback", 12'h00C, 32'h1B1B_1B1B);

    // R4 direct output write
    wr(12'h180, 32'hDEAD_BEEF);
    rd_chk("R4 out readback", 12'h180, 32'hDEAD_BEEF);

    // R5 write-one ports
    wr(12'h008, 32'h5555_5555);
    wr(12'h00C, 32'h5555_5555);
    model = 32'hDEAD_BEEF;
    for (int k = 0; k < 9; k++) begin
      pat = (32'h9E37_79B9 * (k + 1)) ^ (32'h0F0F_0F0F << k);
      case (k % 3)
        0: begin wr(12'h200, pat); model = model | pat; end
        1: begin wr(12'h280, pat); model = model & ~pat; end
        default: begin wr(12'h300, pat); model = model ^ pat; end
      endcase
      rd_chk("R5 out after port write", 12'h180, model);
      #1 chk("R5 pad_out push-pull", pad_out, model);
    end
    rd_chk("R5 set port reads zero", 12'h200, 32'h0);
    rd_chk("R5 toggle port reads zero", 12'h300, 32'h0);

    // R6 sampled inputs and latency
    en = 32'hFFFF_00F0;
    wr(12'h080, en);
    @(negedge clk);
    pad_in = 32'h1234_ABCD;
    rd_chk("R6 input one edge after change", 12'h100, 32'h0);
    rd_chk("R6 input two edges after change", 12'h100, 32'h1234_ABCD & en);
    set_pads(32'hCAFE_5A5A);
    rd_chk("R6 gated input", 12'h100, 32'hCAFE_5A5A & en);

    // R7 sticky edges
    set_pads(32'h0);
    wr(12'h080, 32'hFFFF_FF00);
    wr(12'h380, 32'h0F0F_0F0F);
    wr(12'h400, 32'hFFFF_0000);
    wr(12'h600, 32'hFFFF_FFFF);
    wr(12'h680, 32'hFFFF_FFFF);
    rd_chk("R7 rise cleared", 12'h600, 32'h0);
    set_pads(32'hFFFF_FFFF);
    rd_chk("R7 rise pending", 12'h600, 32'h0F0F_0F00);
    rd_chk("R7 no fall on rise", 12'h680, 32'h0);
    #1 chk("R10 irq level with pending", {31'd0, irq}, 32'h1);
    set_pads(32'h0);
    rd_chk("R7 rise stays after pad falls", 12'h600, 32'h0F0F_0F00);
    rd_chk("R7 fall pending", 12'h680, 32'hFFFF_0000);
    wr(12'h600, 32'h0000_0F00);
    rd_chk("R7 partial write-one clear", 12'h600, 32'h0F0F_0000);
    rd_chk("R9 combined edges", 12'h580, 32'hFFFF_0000);
    wr(12'h600, 32'hFFFF_FFFF);
    wr(12'h680, 32'hFFFF_FFFF);
    rd_chk("R9 combined empty", 12'h580, 32'h0);
    #1 chk("R10 irq low when nothing pending", {31'd0, irq}, 32'h0);

    // R8 level status
    wr(12'h380, 32'h0);
    wr(12'h400, 32'h0);
    wr(12'h080, 32'h00FF_FFFF);
    wr(12'h480, 32'hF0F0_F0F0);
    wr(12'h500, 32'h3333_3333);
    pat = 32'hAAAA_5555;
    set_pads(pat);
    rd_chk("R8 high pending", 12'h700, 32'hF0F0_F0F0 & 32'h00FF_FFFF & pat);
    rd_chk("R8 low pending", 12'h780, 32'h3333_3333 & 32'h00FF_FFFF & ~pat);
    rd_chk("R9 combined levels", 12'h580,
           32'h00FF_FFFF & ((32'hF0F0_F0F0 & pat) | (32'h3333_3333 & ~pat)));
    wr(12'h700, 32'hFFFF_FFFF);
    rd_chk("R8 high pending ignores write", 12'h700, 32'hF0F0_F0F0 & 32'h00FF_FFFF & pat);
    set_pads(~pat);
    rd_chk("R8 high follows level", 12'h700, 32'hF0F0_F0F0 & 32'h00FF_FFFF & ~pat);
    wr(12'h480, 32'h0);
    wr(12'h500, 32'h0);

    // R11 pulse mode
    set_pads(32'h0);
    wr(12'h080, 32'hFFFF_FFFF);
    wr(12'h380, 32'h0000_0001);
    wr(12'h004, 32'h1);
    rd_chk("R11 config readback", 12'h004, 32'h1);
    #1 chk("R11 irq idle in pulse mode", {31'd0, irq}, 32'h0);
    @(negedge clk);
    pad_in = 32'h1;
    repeat (3) @(negedge clk);
    #1 chk("R11 pulse high", {31'd0, irq}, 32'h1);
    @(negedge clk);
    #1 chk("R11 pulse lasts one cycle", {31'd0, irq}, 32'h0);
    rd_chk("R11 status still pending", 12'h600, 32'h1);
    wr(12'h004, 32'h0);
    #1 chk("R10 back to level mode", {31'd0, irq}, 32'h1);
    wr(12'h600, 32'h1);

    // R12 unmapped and read-only
    wr(12'h180, 32'h1357_9BDF);
    wr(12'h084, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h181, 32'h0);
    wr(12'h000, 32'h0);
    wr(12'h100, 32'h0);
    rd_chk("R12 unmapped read", 12'h084, 32'h0);
    rd_chk("R12 top of map read", 12'h7FC, 32'h0);
    rd_chk("R12 misaligned read", 12'h181, 32'h0);
    rd_chk("R12 third mode word absent", 12'h010, 32'h0);
    rd_chk("R12 out untouched", 12'h180, 32'h1357_9BDF);
    rd_chk("R12 gate untouched", 12'h080, 32'hFFFF_FFFF);
    rd_chk("R12 identity untouched", 12'h000, 32'd32 | (32'd3 << 10));
    rd_chk("R12 input follows pads", 12'h100, 32'h1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule